// File: doc/BRIEF.md
# Bus Transfer Timeout Monitor

This block watches bus cycles that leave the chip for the external bus and flags those that are never acknowledged. When such a cycle starts, the monitor loads a down-counter from a programmed limit. A transfer acknowledge clears it. If the counter runs out first, the block raises a one-clock transfer-error acknowledge (`tea`) and treats the cycle as terminated.

The limit is an 8-bit value counted in steps of eight system clocks, so the longest wait is 255 × 8 = 2040 clocks. The limit and an enable bit sit in a configuration register that accepts one write after reset and ignores all later writes until the next reset. Both fields can be read back at any time on dedicated outputs. While the enable bit is clear, no condition can raise `tea`.

Top module: `xtm_bus_monitor`

## Requirements
- R1: After reset the limit read-back is 0xFF, the enable read-back is 0 and `tea` is 0.
- R2: The first clock with `cfg_wr` high after reset loads the limit and the enable bit. Every later write is ignored until the next reset, both in the read-back values and in the timeout behaviour.
- R3: A clock edge that samples `cyc_start` high, with `cyc_ext` high, enable 1 and limit N > 0, arms the monitor. If no acknowledge is sampled, `tea` rises at exactly the 8·N-th clock edge after that edge and stays high for exactly one clock. This holds up to the maximum of 2040 clocks.
- R4: An acknowledge sampled at any edge from the 1st to the 8·N-th after the start edge ends the cycle with no `tea`. This includes the expiry edge itself, where the acknowledge wins.
- R5: While the enable bit is 0, `tea` stays 0 whatever happens on the other inputs.
- R6: A start sampled while `cyc_ext` is 0 is an internal cycle and does not arm the monitor.
- R7: A limit of 0 means no timeout. A start with this limit never leads to `tea`.
- R8: A start sampled while the monitor is already armed restarts the full 8·N interval from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe (effective once after reset) |
| cfg_limit_wr | input | LIMIT_W | Limit to write, in units of STEP clocks |
| cfg_en_wr | input | 1 | Enable bit to write |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_ext | input | 1 | High when the starting cycle goes to the external bus |
| xfer_ack | input | 1 | Transfer acknowledge for the current cycle |
| tea | output | 1 | Transfer-error acknowledge, one-clock pulse on timeout |
| cfg_limit | output | LIMIT_W | Read-back of the stored limit |
| cfg_en | output | 1 | Read-back of the stored enable bit |

## Verification
The bench builds the monitor with its default parameters: an 8-bit limit and a step of eight clocks. With these values the full 2040-clock maximum runs in a few thousand cycles, so the largest limit is checked edge by edge next to small limits. The same build covers the one-step case, an acknowledge one edge before expiry and on the expiry edge, and a restart in mid-count, all at exact edge positions.

// File: rtl/xtm_pkg.sv
package xtm_pkg;
    localparam int unsigned XTM_LIMIT_W = 8;
    localparam int unsigned XTM_STEP    = 8;

    typedef enum logic {
        MON_IDLE  = 1'b0,
        MON_ARMED = 1'b1
    } mon_state_e;
endpackage

// File: rtl/xtm_cfg_reg.sv
module xtm_cfg_reg #(
    parameter int unsigned LIMIT_W = xtm_pkg::XTM_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [LIMIT_W-1:0] limit_wr_i,
    input  logic               en_wr_i,
    output logic [LIMIT_W-1:0] limit_o,
    output logic               en_o
);
    localparam logic [LIMIT_W-1:0] LIMIT_RST = '1;

    typedef struct packed {
        logic [LIMIT_W-1:0] limit;
        logic               en;
        logic               locked;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && !cfg_q.locked) begin
            cfg_d.limit  = limit_wr_i;
            cfg_d.en     = en_wr_i;
            cfg_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.limit  <= LIMIT_RST;
            cfg_q.en     <= 1'b0;
            cfg_q.locked <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign limit_o = cfg_q.limit;
    assign en_o    = cfg_q.en;

    // R2: once locked, the stored fields never move again
    p_write_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.locked |=> ($stable(cfg_q.limit) && $stable(cfg_q.en)));
endmodule

// File: rtl/xtm_step_timer.sv
module xtm_step_timer #(
    parameter int unsigned LIMIT_W = xtm_pkg::XTM_LIMIT_W,
    parameter int unsigned STEP    = xtm_pkg::XTM_STEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               ack_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               tea_o
);
    import xtm_pkg::*;

    localparam int unsigned CNT_W = LIMIT_W + $clog2(STEP) + 1;
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        mon_state_e       st;
        logic [CNT_W-1:0] rem;
        logic             tea;
    } tmr_s;

    tmr_s t_d, t_q;
    logic [CNT_W-1:0] load_d;

    always_comb begin
        load_d = CNT_W'(limit_i) * STEP_C - ONE_C;
        t_d     = t_q;
        t_d.tea = 1'b0;
        if (t_q.st == MON_ARMED) begin
            if (ack_i) begin
                t_d.st = MON_IDLE;
            end else if (t_q.rem == '0) begin
                t_d.tea = 1'b1;
                t_d.st  = MON_IDLE;
            end else begin
                t_d.rem = t_q.rem - ONE_C;
            end
        end
        if (start_i) begin
            if (limit_i == '0) begin
                t_d.st = MON_IDLE;
            end else begin
                t_d.st  = MON_ARMED;
                t_d.rem = load_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.st  <= MON_IDLE;
            t_q.rem <= '0;
            t_q.tea <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tea_o = t_q.tea;

    // R3: the error acknowledge is a single-clock pulse
    p_tea_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.tea |=> !t_q.tea);

    // R4: an acknowledge on an armed cycle forbids an error on the next clock
    p_ack_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == MON_ARMED && ack_i && !start_i) |=> !t_q.tea);

    // R7: a zero limit leaves the monitor unarmed
    p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && limit_i == '0) |=> (t_q.st == MON_IDLE));
endmodule

// File: rtl/xtm_bus_monitor.sv
module xtm_bus_monitor #(
    parameter int unsigned LIMIT_W = xtm_pkg::XTM_LIMIT_W,
    parameter int unsigned STEP    = xtm_pkg::XTM_STEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [LIMIT_W-1:0] cfg_limit_wr,
    input  logic               cfg_en_wr,
    input  logic               cyc_start,
    input  logic               cyc_ext,
    input  logic               xfer_ack,
    output logic               tea,
    output logic [LIMIT_W-1:0] cfg_limit,
    output logic               cfg_en
);
    logic [LIMIT_W-1:0] lim_q;
    logic               en_q;
    logic               arm_d;

    xtm_cfg_reg #(.LIMIT_W(LIMIT_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr),
        .limit_wr_i (cfg_limit_wr),
        .en_wr_i    (cfg_en_wr),
        .limit_o    (lim_q),
        .en_o       (en_q)
    );

    // only enabled cycles bound for the external bus are watched
    always_comb begin
        arm_d = cyc_start && cyc_ext && en_q;
    end

    xtm_step_timer #(.LIMIT_W(LIMIT_W), .STEP(STEP)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (arm_d),
        .ack_i   (xfer_ack),
        .limit_i (lim_q),
        .tea_o   (tea)
    );

    assign cfg_limit = lim_q;
    assign cfg_en    = en_q;

    // R5: a disabled monitor never signals an error
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !tea);

    // R1: reset values on the read-back path
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_limit == '1 && !cfg_en && !tea));
endmodule

// File: tb/test_xtm_bus_monitor.sv
`timescale 1ns/1ps
module test_xtm_bus_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_limit_wr = '0;
    logic       cfg_en_wr = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cyc_ext = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       tea;
    logic [7:0] cfg_limit;
    logic       cfg_en;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xtm_bus_monitor i_xtm_bus_monitor (
        .clk, .rst_n, .cfg_wr, .cfg_limit_wr, .cfg_en_wr,
        .cyc_start, .cyc_ext, .xfer_ack, .tea, .cfg_limit, .cfg_en
    );

    typedef struct packed {
        logic [7:0]  lim;
        logic        en;
        logic        ext;
        logic [11:0] ack_at;   // 0 = no acknowledge
        logic [11:0] exp_at;   // 0 = no error expected
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd1,   1'b1, 1'b1, 12'd0,  12'd8},    // R3 one step
        '{8'd3,   1'b1, 1'b1, 12'd0,  12'd24},   // R3
        '{8'd3,   1'b1, 1'b1, 12'd23, 12'd0},    // R4 one clock early
        '{8'd3,   1'b1, 1'b1, 12'd24, 12'd0},    // R4 on expiry edge
        '{8'd5,   1'b1, 1'b1, 12'd10, 12'd0},    // R4 mid-count
        '{8'd0,   1'b1, 1'b1, 12'd0,  12'd0},    // R7
        '{8'd2,   1'b0, 1'b1, 12'd0,  12'd0},    // R5
        '{8'd2,   1'b1, 1'b0, 12'd0,  12'd0},    // R6
        '{8'd255, 1'b1, 1'b1, 12'd0,  12'd2040}  // R3 maximum
    };
    localparam string VTAG [NV] = '{"R3", "R3", "R4", "R4", "R4", "R7", "R5", "R6", "R3"};

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 1'b0; cyc_start = 1'b0; cyc_ext = 1'b0; xfer_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] lim, input logic en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_limit_wr = lim; cfg_en_wr = en;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // start at edge E0; edge E0+j samples ack/restart; tea expected only after edge E0+exp_at
    task automatic run_cycle(input logic ext, input int ack_at, input int restart_at,
                             input int exp_at, input int len, input string tag);
        int first_bad = 0;
        int bad_val = 0;
        @(negedge clk);
        cyc_start = 1'b1; cyc_ext = ext;
        @(posedge clk);
        @(negedge clk);
        cyc_start = 1'b0;
        for (int j = 1; j <= len; j++) begin
            xfer_ack  = (j == ack_at);
            cyc_start = (j == restart_at);
            @(posedge clk);
            @(negedge clk);
            if (tea !== (j == exp_at) && first_bad == 0) begin
                first_bad = j;
                bad_val = int'(tea);
            end
        end
        xfer_ack = 1'b0; cyc_start = 1'b0;
        check(tag, first_bad == 0, first_bad, exp_at);
        if (first_bad != 0)
            $display("  at edge %0d tea=%0d", first_bad, bad_val);
    endtask

    initial begin
        // R1 reset state
        do_reset();
        check("R1 limit", cfg_limit == 8'hFF, int'(cfg_limit), 255);
        check("R1 enable", cfg_en == 1'b0, int'(cfg_en), 0);
        check("R1 tea", tea == 1'b0, int'(tea), 0);
        // R5 default disabled: full-length cycle gives nothing
        run_cycle(1'b1, 0, 0, 0, 2045, "R5 default");

        // table walk
        for (int v = 0; v < NV; v++) begin
            int len;
            do_reset();
            write_cfg(VECS[v].lim, VECS[v].en);
            len = (VECS[v].lim == 0) ? 40 : int'(VECS[v].lim) * 8 + 4;
            run_cycle(VECS[v].ext, int'(VECS[v].ack_at), 0, int'(VECS[v].exp_at), len, VTAG[v]);
        end

        // R2 write-once
        do_reset();
        write_cfg(8'd1, 1'b1);
        write_cfg(8'd4, 1'b0);
        check("R2 limit", cfg_limit == 8'd1, int'(cfg_limit), 1);
        check("R2 enable", cfg_en == 1'b1, int'(cfg_en), 1);
        run_cycle(1'b1, 0, 0, 8, 40, "R2 behaviour");

        // R8 restart while armed
        do_reset();
        write_cfg(8'd2, 1'b1);
        run_cycle(1'b1, 0, 5, 21, 30, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule